// File: doc/BRIEF.md
# Descriptor Fetch and Chaining Controller

This block sequences the work of one processing channel. The host launches the channel by writing a descriptor pointer into a 32-bit fetch address register. The controller requests a fetch of that descriptor from memory. Once the fetch is acknowledged, it starts an abstract processing engine and waits for the engine to report completion. Memory access, descriptor parsing and the processing itself sit outside the block, behind simple request/acknowledge and start/done handshakes.

The host may write a new pointer while the channel is busy. The controller keeps one such pointer in a pending slot. At the end of every descriptor it looks at that slot before it decides that the chain is over:

- **Pointer present:** the controller fetches it as the next link of the same chain and sends no notification.
- **Slot empty:** the chain ends with a notification. A mode input chooses the kind: either a header writeback request that waits for an acknowledge, or a one-cycle DONE interrupt pulse.

A pointer that arrives after notification has begun is kept. It starts a new chain once the notification has completed.

In writeback mode, descriptor addresses must be word aligned. A misaligned pointer is never fetched. Instead the channel moves to an error state, which it leaves only when the host writes a clear bit.

Top module: `desc_chain_ctrl`

## Requirements
- R1: After reset the fetch address register reads 0, the status word reads 0, and fetch_req, wb_req, done_irq, err_irq and eng_start are all low.
- R2: A host write to the fetch address register (word offset 3) while idle leads to fetch_req with fetch_addr equal to the written value. fetch_req and fetch_addr hold steady until fetch_ack. One eng_start pulse follows the acknowledge.
- R3: A write while a descriptor is in progress does not refetch or restart the current descriptor. The address is held as pending, and status bit 0 (status word at offset 4) reads 1.
- R4: When the engine finishes and a pending pointer exists, that pointer is fetched as the next link and no notification of either kind is issued between the links.
- R5: A write that lands after end-of-chain notification has started does not cancel that notification. The pointer is then fetched as the first descriptor of a new chain, which ends with its own notification.
- R6: With notify_wb low, each chain end raises done_irq for exactly one cycle.
- R7: With notify_wb high, each chain end raises wb_req, with wb_addr equal to the address of the last descriptor of the chain. wb_req stays high and wb_addr stays stable until wb_ack.
- R8: With notify_wb high, a pointer whose bits [1:0] are not 00 is not fetched. The channel enters an error state instead: err_irq goes high and status bit 1 reads 1. A write of 1 to bit 1 of the status word returns the channel to idle. With notify_wb low, unaligned pointers are fetched normally.
- R9: Only one pending pointer is held. A second write before the first is taken overwrites it, so the overwritten address is never fetched.
- R10: A write in the same cycle that the controller takes the pending pointer is kept as a new pending entry and is fetched afterwards.
- R11: The fetch address register reads back the last value written. The reserved word at offset 2 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register word offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for reg_addr |
| notify_wb | input | 1 | 1: header writeback notification, 0: DONE interrupt |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | 32 | Address of the descriptor to fetch |
| fetch_ack | input | 1 | Fetch request accepted |
| eng_start | output | 1 | One-cycle start pulse to the processing engine |
| eng_done | input | 1 | Engine has finished the current descriptor |
| wb_req | output | 1 | Header writeback request |
| wb_addr | output | 32 | Address of the header to write back |
| wb_ack | input | 1 | Writeback completed |
| done_irq | output | 1 | One-cycle end-of-chain interrupt |
| err_irq | output | 1 | Alignment error interrupt, high until cleared |

## Verification
The bench probes the boundary between chaining and fresh chains. It writes a pointer during processing and checks that the chain continues with a single notification. It writes another during an open writeback and checks that two writebacks follow; a design that sampled the pending slot during notification would merge the chains and lose one writeback. Back-to-back writes test two cases: overwrite of the pending slot, where the stale address must never be fetched, and a write in the very cycle the slot is consumed, which a careless priority between set and clear would drop. The misaligned pointer in writeback mode checks that no fetch goes out and that the error stays up until cleared. The same pointer in interrupt mode must still be fetched.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_PROC   = 3'd2,
    ST_CHECK  = 3'd3,
    ST_NOTIFY = 3'd4,
    ST_ERR    = 3'd5
  } dcc_state_t;

  // Descriptor pointer is acceptable for the selected notification mode.
  function automatic logic ptr_ok(input logic [1:0] low_bits, input logic wb_mode);
    return !(wb_mode && (low_bits != 2'b00));
  endfunction

  // Status word layout: bit0 pending valid, bit1 error.
  function automatic logic [31:0] pack_status(input logic pend, input logic err);
    return {30'd0, err, pend};
  endfunction

endpackage

// File: rtl/dcc_hostregs.sv
module dcc_hostregs #(
  parameter int AW       = 3,
  parameter int DW       = 32,
  parameter int OFS_RSV  = 2,
  parameter int OFS_FR   = 3,
  parameter int OFS_STAT = 4,
  parameter int CLR_BIT  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          pend_take,
  input  logic          err_flag,
  output logic          fr_wr,
  output logic          err_clr,
  output logic          pend_vld,
  output logic [DW-1:0] pend_addr
);
  import dcc_pkg::*;

  localparam logic [AW-1:0] A_RSV  = AW'(OFS_RSV);
  localparam logic [AW-1:0] A_FR   = AW'(OFS_FR);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);

  logic [DW-1:0] fr_q;

  assign fr_wr   = reg_wr && (reg_addr == A_FR);
  assign err_clr = reg_wr && (reg_addr == A_STAT) && reg_wdata[CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= '0;
    end else if (fr_wr) begin
      fr_q <= reg_wdata;
    end
  end

  // Single pending slot: a new write wins over a take in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
    end else if (fr_wr) begin
      pend_vld  <= 1'b1;
      pend_addr <= reg_wdata;
    end else if (pend_take) begin
      pend_vld  <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_FR) begin
      reg_rdata = fr_q;
    end else if (reg_addr == A_STAT) begin
      reg_rdata = DW'(pack_status(pend_vld, err_flag));
    end else if (reg_addr == A_RSV) begin
      reg_rdata = '0;
    end
  end

endmodule

// File: rtl/dcc_chain_fsm.sv
module dcc_chain_fsm #(
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                notify_wb,
  input  logic                pend_vld,
  input  logic [DW-1:0]       pend_addr,
  input  logic                fetch_ack,
  input  logic                eng_done,
  input  logic                notify_fin,
  input  logic                err_clr,
  output dcc_pkg::dcc_state_t state,
  output logic                pend_take,
  output logic                chain_continue,
  output logic                align_err,
  output logic [DW-1:0]       cur_addr,
  output logic                fetch_req,
  output logic                eng_start
);
  import dcc_pkg::*;

  dcc_state_t nxt;
  logic       at_decision;
  logic       pend_ok;

  assign at_decision    = (state == ST_IDLE) || (state == ST_CHECK);
  assign pend_ok        = ptr_ok(pend_addr[1:0], notify_wb);
  assign pend_take      = at_decision && pend_vld;
  assign align_err      = pend_take && !pend_ok;
  assign chain_continue = (state == ST_CHECK) && pend_vld && pend_ok;
  assign fetch_req      = (state == ST_FETCH);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (pend_vld) nxt = pend_ok ? ST_FETCH : ST_ERR;
      ST_FETCH:  if (fetch_ack) nxt = ST_PROC;
      ST_PROC:   if (eng_done) nxt = ST_CHECK;
      ST_CHECK:  begin
        if (pend_vld) nxt = pend_ok ? ST_FETCH : ST_ERR;
        else          nxt = ST_NOTIFY;
      end
      ST_NOTIFY: if (notify_fin) nxt = ST_IDLE;
      ST_ERR:    if (err_clr) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      eng_start <= 1'b0;
    end else begin
      state     <= nxt;
      eng_start <= (state == ST_FETCH) && fetch_ack;
      if (pend_take && pend_ok) begin
        cur_addr <= pend_addr;
      end
    end
  end

endmodule

// File: rtl/dcc_notify.sv
module dcc_notify #(
  parameter int DW = 32
) (
  input  logic          notify_act,
  input  logic          notify_wb,
  input  logic [DW-1:0] cur_addr,
  input  logic          wb_ack,
  output logic          wb_req,
  output logic [DW-1:0] wb_addr,
  output logic          done_irq,
  output logic          notify_fin
);
  // NOTIFY lasts one cycle in interrupt mode, so done_irq is a single pulse.
  assign wb_req     = notify_act && notify_wb;
  assign wb_addr    = cur_addr;
  assign done_irq   = notify_act && !notify_wb;
  assign notify_fin = notify_act && (!notify_wb || wb_ack);
endmodule

// File: rtl/desc_chain_ctrl.sv
module desc_chain_ctrl #(
  parameter int AW       = 3,
  parameter int DW       = 32,
  parameter int OFS_RSV  = 2,
  parameter int OFS_FR   = 3,
  parameter int OFS_STAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          notify_wb,
  output logic          fetch_req,
  output logic [DW-1:0] fetch_addr,
  input  logic          fetch_ack,
  output logic          eng_start,
  input  logic          eng_done,
  output logic          wb_req,
  output logic [DW-1:0] wb_addr,
  input  logic          wb_ack,
  output logic          done_irq,
  output logic          err_irq
);
  import dcc_pkg::*;

  dcc_state_t    state;
  logic          fr_wr;
  logic          err_clr;
  logic          pend_vld;
  logic [DW-1:0] pend_addr;
  logic          pend_take;
  logic          chain_continue;
  logic          align_err;
  logic [DW-1:0] cur_addr;
  logic          notify_act;
  logic          notify_fin;

  assign notify_act = (state == ST_NOTIFY);
  assign err_irq    = (state == ST_ERR);
  assign fetch_addr = cur_addr;

  dcc_hostregs #(
    .AW(AW), .DW(DW), .OFS_RSV(OFS_RSV), .OFS_FR(OFS_FR), .OFS_STAT(OFS_STAT), .CLR_BIT(1)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pend_take(pend_take), .err_flag(err_irq),
    .fr_wr(fr_wr), .err_clr(err_clr), .pend_vld(pend_vld), .pend_addr(pend_addr)
  );

  dcc_chain_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .notify_wb(notify_wb),
    .pend_vld(pend_vld), .pend_addr(pend_addr),
    .fetch_ack(fetch_ack), .eng_done(eng_done), .notify_fin(notify_fin), .err_clr(err_clr),
    .state(state), .pend_take(pend_take), .chain_continue(chain_continue),
    .align_err(align_err), .cur_addr(cur_addr), .fetch_req(fetch_req), .eng_start(eng_start)
  );

  dcc_notify #(.DW(DW)) u_notify (
    .notify_act(notify_act), .notify_wb(notify_wb), .cur_addr(cur_addr), .wb_ack(wb_ack),
    .wb_req(wb_req), .wb_addr(wb_addr), .done_irq(done_irq), .notify_fin(notify_fin)
  );

endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_req,
  input logic [DW-1:0] fetch_addr,
  input logic          fetch_ack,
  input logic          eng_start,
  input logic          wb_req,
  input logic [DW-1:0] wb_addr,
  input logic          wb_ack,
  input logic          done_irq,
  input logic          err_irq,
  input logic          fr_wr,
  input logic          pend_vld,
  input logic          chain_continue,
  input logic          align_err
);

  a_r2_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_addr));

  a_r2_start_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && fetch_ack |=> eng_start);

  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  a_r4_no_notify_on_link: assert property (@(posedge clk) disable iff (!rst_n)
    chain_continue |-> !done_irq && !wb_req);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  a_r7_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_addr));

  a_r8_err_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> err_irq && !fetch_req);

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> !fetch_req && !wb_req && !done_irq);

  a_r10_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
    fr_wr |=> pend_vld);

  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req && wb_req));

endmodule

bind desc_chain_ctrl dcc_checker #(.DW(DW)) u_dcc_checker (
  .clk(clk), .rst_n(rst_n),
  .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
  .eng_start(eng_start), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
  .done_irq(done_irq), .err_irq(err_irq), .fr_wr(fr_wr), .pend_vld(pend_vld),
  .chain_continue(chain_continue), .align_err(align_err)
);

// File: tb/test_desc_chain_ctrl.sv
`timescale 1ns/1ps
module test_desc_chain_ctrl;

  localparam int A_RSV = 2, A_FR = 3, A_ST = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        notify_wb = 1'b0;
  logic        fetch_req, eng_start, wb_req, done_irq, err_irq;
  logic [31:0] fetch_addr, wb_addr;
  logic        fetch_ack, eng_done, wb_ack;

  always #2.5 clk = ~clk;

  desc_chain_ctrl i_desc_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .notify_wb(notify_wb),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .eng_start(eng_start), .eng_done(eng_done), .wb_req(wb_req), .wb_addr(wb_addr),
    .wb_ack(wb_ack), .done_irq(done_irq), .err_irq(err_irq)
  );

  int nchk = 0, nfail = 0;
  int eng_lat = 3, wb_lat = 3;
  logic [31:0] flog [32];
  logic [31:0] wlog [32];
  int fcnt = 0, wcnt = 0, done_cnt = 0, done_wide = 0, start_cnt = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Fetch responder: acknowledge one cycle after the request is seen.
  initial begin
    fetch_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (fetch_req && !fetch_ack) begin
        if (fcnt < 32) flog[fcnt] = fetch_addr;
        fcnt++;
        fetch_ack = 1'b1;
      end else begin
        fetch_ack = 1'b0;
      end
    end
  end

  // Engine model: done pulse eng_lat cycles after start.
  initial begin
    eng_done = 1'b0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (eng_start) begin
        start_cnt++;
        repeat (eng_lat - 1) @(negedge clk);
        eng_done = 1'b1;
      end
    end
  end

  // Writeback responder: acknowledge after wb_lat cycles.
  initial begin
    wb_ack = 1'b0;
    forever begin
      @(negedge clk);
      wb_ack = 1'b0;
      if (wb_req) begin
        repeat (wb_lat - 1) @(negedge clk);
        if (wcnt < 32) wlog[wcnt] = wb_addr;
        wcnt++;
        wb_ack = 1'b1;
      end
    end
  end

  // done_irq monitor: counts pulses and flags pulses wider than one cycle.
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (done_irq) done_cnt++;
      if (done_irq && prev) done_wide++;
      prev = done_irq;
    end
  end

  // Host write; caller stands at a negedge.
  task automatic wr(input int ofs, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = 3'(ofs); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int ofs, output logic [31:0] d);
    reg_addr = 3'(ofs);
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_cnt(ref int cnt, input int target);
    int t;
    t = 0;
    while (cnt < target && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_start(input int target);
    int t;
    t = 0;
    while (start_cnt < target && t < 3000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_FR, d);  chk("R1 fetch register reset", d, 32'h0);
    rd(A_ST, d);  chk("R1 status reset", d, 32'h0);
    chk("R1 outputs idle", {27'd0, fetch_req, wb_req, done_irq, err_irq, eng_start}, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(A_RSV, 32'hFFFF_FFFF);
    rd(A_RSV, d); chk("R11 reserved reads zero", d, 32'h0);
    rd(A_FR, d);  chk("R11 reserved write leaves fetch register", d, 32'h0);
    chk("R11 reserved write starts nothing", fcnt, 0);
  endtask

  task automatic t_single_irq();
    logic [31:0] d;
    int f0, d0, s0;
    notify_wb = 1'b0; eng_lat = 3;
    f0 = fcnt; d0 = done_cnt; s0 = start_cnt;
    wr(A_FR, 32'h0000_1000);
    wait_cnt(done_cnt, d0 + 1);
    chk("R2 one fetch", fcnt, f0 + 1);
    chk("R2 fetch address", flog[f0], 32'h0000_1000);
    chk("R2 one engine start", start_cnt, s0 + 1);
    chk("R6 one done pulse", done_cnt, d0 + 1);
    chk("R6 pulse width one cycle", done_wide, 0);
    rd(A_FR, d); chk("R11 readback", d, 32'h0000_1000);
  endtask

  task automatic t_chain();
    logic [31:0] d;
    int f0, d0, s0;
    notify_wb = 1'b0; eng_lat = 20;
    f0 = fcnt; d0 = done_cnt; s0 = start_cnt;
    wr(A_FR, 32'h0000_2000);
    wait_start(s0 + 1);
    repeat (2) @(negedge clk);
    wr(A_FR, 32'h0000_2100);
    rd(A_ST, d); chk("R3 pending shown while busy", d & 32'h1, 32'h1);
    chk("R3 current descriptor not refetched", fcnt, f0 + 1);
    wait_cnt(done_cnt, d0 + 1);
    repeat (30) @(negedge clk);
    chk("R4 two links fetched", fcnt, f0 + 2);
    chk("R4 second link address", flog[f0 + 1], 32'h0000_2100);
    chk("R4 single notification for chain", done_cnt, d0 + 1);
    chk("R3 one start per link", start_cnt, s0 + 2);
  endtask

  task automatic t_overwrite();
    int f0, d0, s0;
    notify_wb = 1'b0; eng_lat = 20;
    f0 = fcnt; d0 = done_cnt; s0 = start_cnt;
    wr(A_FR, 32'h0000_3000);
    wait_start(s0 + 1);
    wr(A_FR, 32'h0000_3100);
    wr(A_FR, 32'h0000_3200);
    wait_cnt(done_cnt, d0 + 1);
    repeat (30) @(negedge clk);
    chk("R9 overwritten entry dropped", fcnt, f0 + 2);
    chk("R9 latest pending fetched", flog[f0 + 1], 32'h0000_3200);
    chk("R9 one notification", done_cnt, d0 + 1);
  endtask

  task automatic t_same_cycle();
    int f0, d0;
    notify_wb = 1'b0; eng_lat = 3;
    f0 = fcnt; d0 = done_cnt;
    wr(A_FR, 32'h0000_4000);
    wr(A_FR, 32'h0000_4100);
    wait_cnt(done_cnt, d0 + 1);
    repeat (20) @(negedge clk);
    chk("R10 write in take cycle kept", fcnt, f0 + 2);
    chk("R10 kept address fetched", flog[f0 + 1], 32'h0000_4100);
    chk("R10 chained, one notification", done_cnt, d0 + 1);
  endtask

  task automatic t_late_wb();
    int f0, w0, t;
    notify_wb = 1'b1; eng_lat = 3; wb_lat = 10;
    f0 = fcnt; w0 = wcnt;
    wr(A_FR, 32'h0000_5000);
    t = 0;
    while (!wb_req && t < 3000) begin @(negedge clk); t++; end
    chk("R7 writeback requested", wb_req, 1'b1);
    chk("R7 writeback address", wb_addr, 32'h0000_5000);
    wr(A_FR, 32'h0000_5100);
    chk("R7 request held until ack", wb_req, 1'b1);
    wait_cnt(wcnt, w0 + 2);
    chk("R5 two writebacks", wcnt, w0 + 2);
    chk("R5 first chain completed", wlog[w0], 32'h0000_5000);
    chk("R5 new chain notified", wlog[w0 + 1], 32'h0000_5100);
    chk("R5 new chain fetched", flog[f0 + 1], 32'h0000_5100);
    wb_lat = 3;
  endtask

  task automatic t_align();
    logic [31:0] d;
    int f0, d0;
    notify_wb = 1'b1; eng_lat = 3;
    f0 = fcnt;
    wr(A_FR, 32'h0000_6002);
    repeat (3) @(negedge clk);
    chk("R8 error raised", err_irq, 1'b1);
    chk("R8 no fetch", fcnt, f0);
    rd(A_ST, d); chk("R8 status error bit", d, 32'h2);
    repeat (5) @(negedge clk);
    chk("R8 error held", err_irq, 1'b1);
    wr(A_ST, 32'h2);
    chk("R8 error cleared", err_irq, 1'b0);
    notify_wb = 1'b0;
    d0 = done_cnt;
    wr(A_FR, 32'h0000_6003);
    wait_cnt(done_cnt, d0 + 1);
    chk("R8 unaligned fetched in interrupt mode", flog[f0], 32'h0000_6003);
    chk("R8 no error in interrupt mode", err_irq, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_single_irq();
    t_chain();
    t_overwrite();
    t_same_cycle();
    t_late_wb();
    t_align();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule